// File: doc/BRIEF.md
# Remote Terminal Command Acceptance and Status Composer

This block sits behind the word decoder of a serial-bus remote terminal. On each received command word (a one-cycle `cmd_valid` pulse with the 16-bit word) it works out whether the command is meant for this terminal. A command can be meant for it because it names the strapped terminal address, or because it is a broadcast. The block also flags mode commands and sets an in-command indication that lasts until the status word is sent. It checks the strapped address continuously against its parity strap and reports an error on an active-low output.

When the transmitter is about to send a status word, it pulses `status_update`. The block then builds the 16-bit status word from three sources:
- the strapped address;
- what it recorded about the last accepted command;
- the host request inputs, sampled at that moment.

A latched terminal-fail flag collects self-test and watchdog faults. It is reported in the status word and cleared when a status word starts, unless a fault is present in that same cycle.

Command word layout: bits 15:11 target address, bit 10 transmit/receive, bits 9:5 subaddress, bits 4:0 word count or mode code.

Top module: `rt_cmd_status`

## Requirements
- R1: `addr_good` is high exactly when the XOR of `term_addr[4:0]` and `term_addr_par` is 1 (odd parity); low signals an address-parity error.
- R2: A command whose address field equals `term_addr` while `addr_good` is high is accepted: `cmd_accept` is high for exactly the one cycle after the `cmd_valid` cycle, with `cmd_bcast` low. Any other non-broadcast command leaves `cmd_accept` low.
- R3: While `addr_good` is low, a command with an address other than a recognised broadcast is ignored: no `cmd_accept`, `in_cmd` unchanged, and the status-word fields it would set are unchanged.
- R4: With `bcast_en` high, a command with address 31 is accepted as broadcast whatever `term_addr` and its parity are; `cmd_bcast` is high together with `cmd_accept`.
- R5: With `bcast_en` low, address 31 is accepted only as an own-address command, that is when `term_addr` is 31 and `addr_good` is high; `cmd_bcast` stays low.
- R6: `cmd_mode` is high together with `cmd_accept` when the subaddress field is 00000 or 11111. It is low for any other subaddress.
- R7: `in_cmd` rises on the edge that accepts a command and falls on the edge where `status_update` is high. A command that is not accepted does not change it.
- R8: Status bit 10 (message error) takes the value of `host_illegal_n` inverted, sampled on the edge that accepts the command. It keeps that value through the following status update.
- R9: Status bit 8 (service request) is 1 when `host_srq_n` is low on the `status_update` edge, and 0 when it is high.
- R10: Status bit 4 is 1 when the last accepted command before the update was a broadcast.
- R11: Status bit 1 (bus control accepted) is 1 only under all of these conditions:
  - `host_dbca_n` is low at the update;
  - the last accepted command had transmit/receive = 1, a mode subaddress and mode code 00000;
  - that command was legal.
- R12: A high `selftest_fail` or `wdog_timeout` drives `term_fail_n` low from the next cycle. On a `status_update` edge the flag clears unless a fault input is high in that same cycle. Status bit 0 is 1 when the flag was set or a fault is present at the update.
- R13: `status_word` is zero after reset and changes only on `status_update` edges. Bits 15:11 then carry `term_addr`, and bits 9, 7:5, 3 and 2 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle pulse: cmd_word holds a received command |
| cmd_word | input | 16 | Received command word |
| term_addr | input | 5 | Strapped terminal address |
| term_addr_par | input | 1 | Strapped parity bit for term_addr (odd parity) |
| bcast_en | input | 1 | High enables recognition of address 31 as broadcast |
| host_illegal_n | input | 1 | Active-low: host declares the command illegal |
| host_srq_n | input | 1 | Active-low service request from host |
| host_dbca_n | input | 1 | Active-low: host accepts bus control |
| selftest_fail | input | 1 | Continuous self-test failure event |
| wdog_timeout | input | 1 | Watchdog timeout event |
| status_update | input | 1 | One-cycle pulse at start of status word transmission |
| addr_good | output | 1 | High when strapped address parity is correct |
| cmd_accept | output | 1 | One-cycle pulse: last command accepted |
| cmd_bcast | output | 1 | Accepted command was broadcast |
| cmd_mode | output | 1 | Accepted command was a mode command |
| in_cmd | output | 1 | High while a command is being serviced |
| status_word | output | 16 | Composed status word |
| term_fail_n | output | 1 | Latched active-low terminal fail flag |

## Verification
The assertions assume that `term_addr` and `term_addr_par` are static straps, which hold still for at least a cycle around each command. They also assume that `cmd_valid` and `status_update` never pulse in the same cycle. The bench changes the straps only while no command is pending, and issues each command, and any status update, in separate cycles. The outputs are sampled on the falling edge after the capturing edge. Fault pulses are applied on their own and also together with an update, since that coincidence is the one case the flag's clear rule singles out.

// File: rtl/rt_cmd_status.sv
module rt_cmd_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [15:0] cmd_word,
  input  logic [4:0]  term_addr,
  input  logic        term_addr_par,
  input  logic        bcast_en,
  input  logic        host_illegal_n,
  input  logic        host_srq_n,
  input  logic        host_dbca_n,
  input  logic        selftest_fail,
  input  logic        wdog_timeout,
  input  logic        status_update,
  output logic        addr_good,
  output logic        cmd_accept,
  output logic        cmd_bcast,
  output logic        cmd_mode,
  output logic        in_cmd,
  output logic [15:0] status_word,
  output logic        term_fail_n
);

  logic [4:0] c_addr;
  logic [4:0] c_sub;
  logic [4:0] c_code;
  logic       c_tr;
  logic       bc_hit;
  logic       own_hit;
  logic       take;
  logic       is_mode;
  logic       is_dbc;
  logic       fault;

  logic       last_me;
  logic       last_bc;
  logic       last_dbc;
  logic       fail_lat;

  assign c_addr  = cmd_word[15:11];
  assign c_tr    = cmd_word[10];
  assign c_sub   = cmd_word[9:5];
  assign c_code  = cmd_word[4:0];

  assign addr_good = ^{term_addr, term_addr_par};

  assign bc_hit  = bcast_en & (&c_addr);
  assign own_hit = addr_good & (c_addr == term_addr) & ~bc_hit;
  assign take    = cmd_valid & (bc_hit | own_hit);

  assign is_mode = (c_sub == 5'd0) | (&c_sub);
  assign is_dbc  = c_tr & is_mode & (c_code == 5'd0);

  assign fault   = selftest_fail | wdog_timeout;

  assign term_fail_n = ~fail_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_accept <= 1'b0;
      cmd_bcast  <= 1'b0;
      cmd_mode   <= 1'b0;
    end else begin
      cmd_accept <= take;
      cmd_bcast  <= take & bc_hit;
      cmd_mode   <= take & is_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cmd   <= 1'b0;
      last_me  <= 1'b0;
      last_bc  <= 1'b0;
      last_dbc <= 1'b0;
    end else if (take) begin
      in_cmd   <= 1'b1;
      last_me  <= ~host_illegal_n;
      last_bc  <= bc_hit;
      last_dbc <= is_dbc;
    end else if (status_update) begin
      in_cmd   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      status_word <= 16'h0000;
    else if (status_update)
      status_word <= {term_addr, last_me, 1'b0, ~host_srq_n, 3'b000,
                      last_bc, 2'b00, ~host_dbca_n & last_dbc & ~last_me,
                      fail_lat | fault};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fail_lat <= 1'b0;
    else if (fault)
      fail_lat <= 1'b1;
    else if (status_update)
      fail_lat <= 1'b0;
  end

endmodule

module rt_cmd_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        bcast_en,
  input logic        selftest_fail,
  input logic        wdog_timeout,
  input logic        status_update,
  input logic        addr_good,
  input logic        cmd_accept,
  input logic        cmd_bcast,
  input logic        cmd_mode,
  input logic        in_cmd,
  input logic [15:0] status_word,
  input logic        term_fail_n
);

  AST_ACCEPT_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> $past(cmd_valid)); // R2
  AST_PARITY_BLOCKS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && !cmd_bcast) |-> $past(addr_good)); // R3
  AST_BCAST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bcast |-> (cmd_accept && $past(bcast_en))); // R4
  AST_MODE_WITH_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mode |-> cmd_accept); // R6
  AST_INCMD_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> in_cmd); // R7
  AST_FAULT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (selftest_fail || wdog_timeout) |=> !term_fail_n); // R12
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !status_update |=> $stable(status_word)); // R13
  AST_STATUS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[9] | status_word[7] | status_word[6] | status_word[5] |
     status_word[3] | status_word[2]) == 1'b0); // R13
  AST_DBCA_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[1] |-> !status_word[10]); // R11

endmodule

bind rt_cmd_status rt_cmd_status_chk u_chk (.*);

// File: tb/tb_rt_cmd_status.sv
module tb_rt_cmd_status;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = 16'h0;
  logic [4:0]  term_addr = 5'd0;
  logic        term_addr_par = 1'b1;
  logic        bcast_en = 1'b0;
  logic        host_illegal_n = 1'b1;
  logic        host_srq_n = 1'b1;
  logic        host_dbca_n = 1'b1;
  logic        selftest_fail = 1'b0;
  logic        wdog_timeout = 1'b0;
  logic        status_update = 1'b0;
  logic        addr_good, cmd_accept, cmd_bcast, cmd_mode, in_cmd, term_fail_n;
  logic [15:0] status_word;

  int checks = 0;
  int errors = 0;
  logic m_me = 1'b0, m_bc = 1'b0, m_dbc = 1'b0, m_fail = 1'b0, m_in = 1'b0;

  always #2.5 clk = ~clk;

  rt_cmd_status dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input logic ill_n);
    @(negedge clk);
    cmd_word = w; host_illegal_n = ill_n; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; host_illegal_n = 1'b1;
  endtask

  function automatic logic [15:0] exp_status(input logic srq_n, input logic dbca_n, input logic flt);
    return {term_addr, m_me, 1'b0, ~srq_n, 3'b000, m_bc, 2'b00,
            ~dbca_n & m_dbc & ~m_me, m_fail | flt};
  endfunction

  task automatic update(input logic srq_n, input logic dbca_n, input logic flt);
    logic [15:0] e;
    @(negedge clk);
    host_srq_n = srq_n; host_dbca_n = dbca_n; status_update = 1'b1;
    selftest_fail = flt;
    e = exp_status(srq_n, dbca_n, flt);
    @(negedge clk);
    status_update = 1'b0; selftest_fail = 1'b0;
    m_fail = flt; m_in = 1'b0;
    chk("R13 R9 R10 R11 status", status_word, e);
    chk("R7 in_cmd clear", {15'd0, in_cmd}, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 reset status", status_word, 16'h0);
    chk("R12 reset fail", {15'd0, term_fail_n}, 16'd1);
    chk("R2 reset accept", {15'd0, cmd_accept}, 16'd0);
    rst_n = 1'b1;

    for (int ta = 0; ta < 32; ta++) begin
      for (int p = 0; p < 2; p++) begin
        for (int be = 0; be < 2; be++) begin
          @(negedge clk);
          term_addr = 5'(ta); term_addr_par = 1'(p); bcast_en = 1'(be);
          #1;
          chk("R1 parity", {15'd0, addr_good}, {15'd0, ^{5'(ta), 1'(p)}});
          for (int ca = 0; ca < 32; ca++) begin
            logic good, bc, own, acc, ill;
            good = ^{5'(ta), 1'(p)};
            bc   = (be == 1) && (ca == 31);
            own  = good && (ca == ta) && !bc;
            acc  = bc || own;
            ill  = ca[0] ^ ta[1];
            send({5'(ca), 1'b0, 5'd3, 5'd2}, ~ill);
            chk(bc ? "R4 broadcast" : (good ? "R2 R5 own address" : "R3 parity error"),
                {13'd0, cmd_accept, cmd_bcast, cmd_mode}, {13'd0, acc, bc, 1'b0});
            if (acc) begin m_me = ill; m_bc = bc; m_dbc = 1'b0; m_in = 1'b1; end
            @(negedge clk);
            chk("R7 in_cmd", {15'd0, in_cmd}, {15'd0, m_in});
            chk("R2 accept one cycle", {15'd0, cmd_accept}, 16'd0);
            if (ca % 8 == 0 || acc) update(1'(ca[1]), 1'b1, 1'b0);
          end
        end
      end
    end

    @(negedge clk);
    term_addr = 5'd9; term_addr_par = 1'b1; bcast_en = 1'b1;
    for (int sa = 0; sa < 32; sa++) begin
      for (int tr = 0; tr < 2; tr++) begin
        for (int code = 0; code < 2; code++) begin
          for (int ill = 0; ill < 2; ill++) begin
            for (int db = 0; db < 2; db++) begin
              logic md;
              md = (sa == 0) || (sa == 31);
              send({5'd9, 1'(tr), 5'(sa), 5'(code)}, ~1'(ill));
              chk("R6 mode", {14'd0, cmd_accept, cmd_mode}, {14'd0, 1'b1, md});
              m_me = 1'(ill); m_bc = 1'b0; m_dbc = md && (tr == 1) && (code == 0);
              update(1'b1, ~1'(db), 1'b0);
            end
          end
        end
      end
    end

    send({5'd31, 1'b1, 5'd0, 5'd0}, 1'b1);
    m_me = 1'b0; m_bc = 1'b1; m_dbc = 1'b1;
    update(1'b0, 1'b0, 1'b0);
    chk("R8 R10 broadcast status bits", {status_word[10], status_word[4]}, 2'b01);

    @(negedge clk);
    host_srq_n = 1'b0; host_dbca_n = 1'b1; wdog_timeout = 1'b0;
    send({5'd3, 1'b0, 5'd1, 5'd1}, 1'b0);
    repeat (3) @(negedge clk);
    chk("R13 status holds between updates", status_word, exp_status(1'b0, 1'b0, 1'b0));

    @(negedge clk); selftest_fail = 1'b1;
    @(negedge clk); selftest_fail = 1'b0;
    chk("R12 self-test latch", {15'd0, term_fail_n}, 16'd0);
    repeat (2) @(negedge clk);
    chk("R12 latch holds", {15'd0, term_fail_n}, 16'd0);
    m_fail = 1'b1;
    update(1'b1, 1'b1, 1'b0);
    chk("R12 cleared at update", {15'd0, term_fail_n}, 16'd1);
    @(negedge clk); wdog_timeout = 1'b1;
    @(negedge clk); wdog_timeout = 1'b0;
    chk("R12 watchdog latch", {15'd0, term_fail_n}, 16'd0);
    m_fail = 1'b1;
    update(1'b1, 1'b1, 1'b1);
    chk("R12 persists with fault at update", {15'd0, term_fail_n}, 16'd0);
    update(1'b1, 1'b1, 1'b0);
    chk("R12 clears after fault gone", {15'd0, term_fail_n}, 16'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule